// File: doc/BRIEF.md
# Two-Bus Microcoded Multicycle Processor Core

This block is a small multicycle processor whose datapath has no point-to-point wiring between its state elements. Every transfer crosses one of two shared buses. In each cycle a microinstruction picks the source of each bus, the ALU operation, the single state element that is written at the clock edge, and how the micro-program counter moves on.

The core keeps its own microcode ROM, micro-program counter and opcode dispatch. Its datapath state is the program counter, the instruction register, two operand latches, an ALU result latch, a memory data latch, a register file and one unified word-addressed memory. The register file and the memory both read asynchronously.

The supported instructions are register add, add-immediate, load word, store word and branch-if-not-equal. A load port writes the memory while the core is held in reset, and a peek port reads it afterwards. The program counter and a fetch indicator are brought out so that instruction timing can be observed.

Top module: `twobus_core`

## Requirements
- R1: Instruction words hold the opcode in bits [31:26], rs in [25:21], rt in [20:16], rd in [15:11] and a 16-bit immediate in [15:0]. The memory and the PC count in words. In a fetch cycle (fetch_o high) the word at the PC is loaded into the instruction register and the PC advances by one.
- R2: After the decode cycle the micro-PC jumps to an opcode-specific routine whose micro-address is a multiple of four. The opcodes are 0x00 add, 0x08 add-immediate, 0x23 load, 0x2B store and 0x05 branch-if-not-equal.
- R3: Register add (rd = rs + rt) takes 4 cycles from fetch to the next fetch.
- R4: Add-immediate writes rt = rs + sign-extended immediate and takes 4 cycles.
- R5: Load word writes rt = mem[rs + sign-extended immediate] and takes 5 cycles.
- R6: Store word writes the value of rt to mem[rs + sign-extended immediate] and takes 4 cycles.
- R7: Branch-if-not-equal with equal operands returns to fetch after 3 cycles, and the PC only advances by one. With unequal operands it takes 4 cycles and sets the PC to the incremented PC plus the sign-extended immediate.
- R8: Register 0 reads as zero, and writes to it have no effect.
- R9: An unknown opcode returns to fetch after 2 cycles and changes no register or memory word.
- R10: In each cycle only the destination named by the microinstruction is written. The instruction register holds its value outside fetch, and a memory store always follows an address computation.
- R11: While reset is asserted the PC is 0 and the micro-PC sits at the fetch step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, synchronised internally on release |
| ld_we | input | 1 | Memory load strobe, used while the core is held in reset |
| ld_addr | input | AW | Memory load word address |
| ld_data | input | XLEN | Memory load data |
| peek_addr | input | AW | Memory peek word address |
| peek_data | output | XLEN | Asynchronous memory read at peek_addr |
| pc_o | output | XLEN | Current program counter |
| fetch_o | output | 1 | High while the micro-PC is at the fetch step |

## Verification
Each instruction's result becomes visible at the start of the fetch that follows it. That is 4 cycles after its fetch for add, add-immediate, store and a taken branch, 5 for a load, 3 for an untaken branch and 2 for an unknown opcode. The bench samples at falling edges and marks every rising edge of fetch_o as an instruction boundary. It compares the PC at each boundary and the cycle distance between boundaries with these counts. Memory results are read through the peek port only after the program has settled into its final branch loop, well past the last store.

// File: rtl/twobus_pkg.sv
package twobus_pkg;

  localparam int UPC_W = 5;
  localparam int OPC_W = 6;

  typedef enum logic [1:0] {SA_NONE, SA_PC, SA_A, SA_S} srca_e;
  typedef enum logic [2:0] {SB_NONE, SB_B, SB_MEM, SB_SX, SB_ZX, SB_S, SB_M} srcb_e;
  typedef enum logic [0:0] {ALU_ADD, ALU_SUB} aluop_e;
  typedef enum logic [3:0] {D_NONE, D_IR, D_AB, D_S, D_M, D_RF_RD, D_RF_RT, D_MEM, D_PC} dest_e;
  typedef enum logic [1:0] {SQ_NEXT, SQ_FETCH, SQ_DISP, SQ_ZFETCH} seq_e;

  typedef struct packed {
    srca_e  sa;
    srcb_e  sb;
    aluop_e alu;
    dest_e  dst;
    seq_e   sq;
  } uinst_t;

  localparam logic [OPC_W-1:0] OP_ADD  = 6'h00;
  localparam logic [OPC_W-1:0] OP_ADDI = 6'h08;
  localparam logic [OPC_W-1:0] OP_LW   = 6'h23;
  localparam logic [OPC_W-1:0] OP_SW   = 6'h2B;
  localparam logic [OPC_W-1:0] OP_BNE  = 6'h05;

  localparam logic [UPC_W-1:0] UA_FETCH  = 5'd0;
  localparam logic [UPC_W-1:0] UA_DECODE = 5'd1;
  localparam logic [UPC_W-1:0] UA_ADD    = 5'd4;
  localparam logic [UPC_W-1:0] UA_ADDI   = 5'd8;
  localparam logic [UPC_W-1:0] UA_LW     = 5'd12;
  localparam logic [UPC_W-1:0] UA_SW     = 5'd16;
  localparam logic [UPC_W-1:0] UA_BNE    = 5'd20;

  function automatic uinst_t mk(srca_e a, srcb_e b, aluop_e o, dest_e d, seq_e s);
    uinst_t u;
    u.sa  = a;
    u.sb  = b;
    u.alu = o;
    u.dst = d;
    u.sq  = s;
    return u;
  endfunction

  function automatic uinst_t ucode_word(logic [UPC_W-1:0] ua);
    case (ua)
      UA_FETCH:    return mk(SA_PC,   SB_MEM,  ALU_ADD, D_IR,    SQ_NEXT);
      UA_DECODE:   return mk(SA_NONE, SB_NONE, ALU_ADD, D_AB,    SQ_DISP);
      UA_ADD:      return mk(SA_A,    SB_B,    ALU_ADD, D_S,     SQ_NEXT);
      UA_ADD + 1:  return mk(SA_NONE, SB_S,    ALU_ADD, D_RF_RD, SQ_FETCH);
      UA_ADDI:     return mk(SA_A,    SB_SX,   ALU_ADD, D_S,     SQ_NEXT);
      UA_ADDI + 1: return mk(SA_NONE, SB_S,    ALU_ADD, D_RF_RT, SQ_FETCH);
      UA_LW:       return mk(SA_A,    SB_SX,   ALU_ADD, D_S,     SQ_NEXT);
      UA_LW + 1:   return mk(SA_S,    SB_MEM,  ALU_ADD, D_M,     SQ_NEXT);
      UA_LW + 2:   return mk(SA_NONE, SB_M,    ALU_ADD, D_RF_RT, SQ_FETCH);
      UA_SW:       return mk(SA_A,    SB_SX,   ALU_ADD, D_S,     SQ_NEXT);
      UA_SW + 1:   return mk(SA_S,    SB_B,    ALU_ADD, D_MEM,   SQ_FETCH);
      UA_BNE:      return mk(SA_A,    SB_B,    ALU_SUB, D_NONE,  SQ_ZFETCH);
      UA_BNE + 1:  return mk(SA_PC,   SB_SX,   ALU_ADD, D_PC,    SQ_FETCH);
      default:     return mk(SA_NONE, SB_NONE, ALU_ADD, D_NONE,  SQ_FETCH);
    endcase
  endfunction

  function automatic logic [UPC_W-1:0] dispatch_target(logic [OPC_W-1:0] op);
    case (op)
      OP_ADD:  return UA_ADD;
      OP_ADDI: return UA_ADDI;
      OP_LW:   return UA_LW;
      OP_SW:   return UA_SW;
      OP_BNE:  return UA_BNE;
      default: return UA_FETCH;
    endcase
  endfunction

endpackage

// File: rtl/twobus_useq.sv
module twobus_useq
  import twobus_pkg::*;
(
  input  logic             clk,
  input  logic             rst_ni,
  input  logic [OPC_W-1:0] opcode,
  input  logic             alu_zero,
  output logic [UPC_W-1:0] upc_o,
  output uinst_t           uinst_o
);

  logic [UPC_W-1:0] upc_q;
  logic [UPC_W-1:0] upc_d;
  uinst_t           uw;

  always_comb begin
    uw = ucode_word(upc_q);
    case (uw.sq)
      SQ_NEXT:   upc_d = upc_q + 1'b1;
      SQ_FETCH:  upc_d = UA_FETCH;
      SQ_DISP:   upc_d = dispatch_target(opcode);
      SQ_ZFETCH: upc_d = alu_zero ? UA_FETCH : upc_q + 1'b1;
      default:   upc_d = UA_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) upc_q <= UA_FETCH;
    else         upc_q <= upc_d;
  end

  assign upc_o   = upc_q;
  assign uinst_o = uw;

  // R2: every routine entered from decode starts on a four-word boundary
  p_disp_align_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    (upc_q == UA_DECODE) |=> (upc_q[1:0] == 2'b00));

  // R9: an unknown opcode goes straight back to fetch
  p_unknown_op_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    (upc_q == UA_DECODE && opcode != OP_ADD && opcode != OP_ADDI &&
     opcode != OP_LW && opcode != OP_SW && opcode != OP_BNE) |=> (upc_q == UA_FETCH));

  // R7: an equal compare in the branch step ends the instruction
  p_bne_equal_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    (upc_q == UA_BNE && alu_zero) |=> (upc_q == UA_FETCH));

endmodule

// File: rtl/twobus_regfile.sv
module twobus_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int RAW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            we,
  input  logic [RAW-1:0]  waddr,
  input  logic [XLEN-1:0] wdata,
  input  logic [RAW-1:0]  raddr_a,
  input  logic [RAW-1:0]  raddr_b,
  output logic [XLEN-1:0] rdata_a,
  output logic [XLEN-1:0] rdata_b
);

  logic [XLEN-1:0] regs [1:NREG-1];

  for (genvar g = 1; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (we && waddr == RAW'(g)) regs[g] <= wdata;
    end
  end

  always_comb begin
    rdata_a = (raddr_a == '0) ? '0 : regs[raddr_a];
    rdata_b = (raddr_b == '0) ? '0 : regs[raddr_b];
  end

endmodule

// File: rtl/twobus_mem.sv
module twobus_mem #(
  parameter int XLEN = 32,
  parameter int AW   = 6,
  localparam int DEPTH = 1 << AW
) (
  input  logic            clk,
  input  logic            we,
  input  logic [AW-1:0]   addr,
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] rdata,
  input  logic            ld_we,
  input  logic [AW-1:0]   ld_addr,
  input  logic [XLEN-1:0] ld_data,
  input  logic [AW-1:0]   peek_addr,
  output logic [XLEN-1:0] peek_data
);

  logic [XLEN-1:0] words [DEPTH];

  always_ff @(posedge clk) begin
    if (ld_we)   words[ld_addr] <= ld_data;
    else if (we) words[addr]    <= wdata;
  end

  assign rdata     = words[addr];
  assign peek_data = words[peek_addr];

endmodule

// File: rtl/twobus_core.sv
module twobus_core
  import twobus_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int AW   = 6,
  parameter int NREG = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ld_we,
  input  logic [AW-1:0]   ld_addr,
  input  logic [XLEN-1:0] ld_data,
  input  logic [AW-1:0]   peek_addr,
  output logic [XLEN-1:0] peek_data,
  output logic [XLEN-1:0] pc_o,
  output logic            fetch_o
);

  localparam int RAW   = $clog2(NREG);
  localparam int IMM_W = 16;

  // reset: asserted asynchronously, released through two flops
  logic rst_s1, rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_ni <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_ni <= rst_s1;
    end
  end

  logic [XLEN-1:0] pc_q, pc_d, ir_q, ir_d, a_q, a_d, b_q, b_d, s_q, s_d, m_q, m_d;
  logic            pc_en, ir_en, ab_en, s_en, m_en;
  logic [XLEN-1:0] bus_a, bus_b, alu_y, imm_sx, imm_zx, mem_rdata, rf_a, rf_b;
  logic            alu_zero, rf_we, mem_we;
  logic [RAW-1:0]  rf_waddr;
  logic [UPC_W-1:0] upc;
  uinst_t          ui;

  twobus_useq u_useq (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .opcode   (ir_q[31:26]),
    .alu_zero (alu_zero),
    .upc_o    (upc),
    .uinst_o  (ui)
  );

  assign imm_sx = {{(XLEN-IMM_W){ir_q[IMM_W-1]}}, ir_q[IMM_W-1:0]};
  assign imm_zx = {{(XLEN-IMM_W){1'b0}}, ir_q[IMM_W-1:0]};

  // bus sources
  always_comb begin
    case (ui.sa)
      SA_PC:   bus_a = pc_q;
      SA_A:    bus_a = a_q;
      SA_S:    bus_a = s_q;
      default: bus_a = '0;
    endcase
    case (ui.sb)
      SB_B:    bus_b = b_q;
      SB_MEM:  bus_b = mem_rdata;
      SB_SX:   bus_b = imm_sx;
      SB_ZX:   bus_b = imm_zx;
      SB_S:    bus_b = s_q;
      SB_M:    bus_b = m_q;
      default: bus_b = '0;
    endcase
  end

  assign alu_y    = (ui.alu == ALU_SUB) ? bus_a - bus_b : bus_a + bus_b;
  assign alu_zero = (alu_y == '0);

  // write enables and next-state values
  always_comb begin
    ir_en = (ui.dst == D_IR);
    ab_en = (ui.dst == D_AB);
    s_en  = (ui.dst == D_S);
    m_en  = (ui.dst == D_M);
    pc_en = (ui.dst == D_IR) || (ui.dst == D_PC);
    rf_we = (ui.dst == D_RF_RD) || (ui.dst == D_RF_RT);
    mem_we = (ui.dst == D_MEM);
    ir_d  = bus_b;
    a_d   = rf_a;
    b_d   = rf_b;
    s_d   = alu_y;
    m_d   = bus_b;
    pc_d  = (ui.dst == D_PC) ? alu_y : pc_q + 1'b1;
    rf_waddr = (ui.dst == D_RF_RD) ? ir_q[11 +: RAW] : ir_q[16 +: RAW];
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= '0;
      ir_q <= '0;
      a_q  <= '0;
      b_q  <= '0;
      s_q  <= '0;
      m_q  <= '0;
    end else begin
      if (pc_en) pc_q <= pc_d;
      if (ir_en) ir_q <= ir_d;
      if (ab_en) begin
        a_q <= a_d;
        b_q <= b_d;
      end
      if (s_en) s_q <= s_d;
      if (m_en) m_q <= m_d;
    end
  end

  twobus_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
    .clk     (clk),
    .we      (rf_we),
    .waddr   (rf_waddr),
    .wdata   (bus_b),
    .raddr_a (ir_q[21 +: RAW]),
    .raddr_b (ir_q[16 +: RAW]),
    .rdata_a (rf_a),
    .rdata_b (rf_b)
  );

  twobus_mem #(.XLEN(XLEN), .AW(AW)) u_mem (
    .clk       (clk),
    .we        (mem_we),
    .addr      (bus_a[AW-1:0]),
    .wdata     (bus_b),
    .rdata     (mem_rdata),
    .ld_we     (ld_we),
    .ld_addr   (ld_addr),
    .ld_data   (ld_data),
    .peek_addr (peek_addr),
    .peek_data (peek_data)
  );

  assign pc_o    = pc_q;
  assign fetch_o = (upc == UA_FETCH);

  // R1: a fetch cycle advances the PC by exactly one word
  p_pc_step_r1: assert property (@(posedge clk) disable iff (!rst_ni)
    (upc == UA_FETCH) |=> (pc_q == $past(pc_q) + 1'b1));

  // R7: the second branch step lands on incremented PC plus offset
  p_bne_target_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    (upc == UA_BNE + 1'b1) |=> (pc_q == $past(pc_q) + $past(imm_sx)));

  // R10: the instruction register only changes in fetch
  p_ir_hold_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    (upc != UA_FETCH) |=> $stable(ir_q));

  // R10: a store is always preceded by an address computation into S
  p_store_after_addr_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    (upc == UA_SW) |=> mem_we);

  // R11: reset parks the micro-PC at fetch
  p_reset_fetch_r11: assert property (@(posedge clk)
    (!rst_ni) |-> fetch_o);

endmodule

// File: tb/twobus_core_bench.sv
`timescale 1ns/1ps
module twobus_core_bench;

  localparam int XLEN = 32;
  localparam int AW   = 6;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            ld_we;
  logic [AW-1:0]   ld_addr;
  logic [XLEN-1:0] ld_data;
  logic [AW-1:0]   peek_addr;
  logic [XLEN-1:0] peek_data;
  logic [XLEN-1:0] pc_o;
  logic            fetch_o;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  twobus_core #(.XLEN(XLEN), .AW(AW), .NREG(32)) u_twobus_core (
    .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
    .peek_addr(peek_addr), .peek_data(peek_data), .pc_o(pc_o), .fetch_o(fetch_o)
  );

  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction
  function automatic logic [31:0] enc_r(int rs, int rt, int rd);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 11'h0};
  endfunction

  function automatic logic [31:0] program_word(int a);
    case (a)
      0:  return enc_i(6'h08, 0, 1, 5);      // ADDI r1 = 5
      1:  return enc_i(6'h08, 0, 2, -3);     // ADDI r2 = -3
      2:  return enc_r(1, 2, 3);             // ADD r3 = r1 + r2
      3:  return enc_i(6'h23, 0, 4, 40);     // LW r4 = mem[40]
      4:  return enc_r(4, 3, 5);             // ADD r5 = r4 + r3
      5:  return enc_i(6'h2B, 0, 5, 48);     // SW r5 -> 48
      6:  return enc_i(6'h2B, 0, 3, 49);     // SW r3 -> 49
      7:  return enc_i(6'h05, 1, 1, 5);      // BNE r1, r1 (not taken)
      8:  return enc_i(6'h3F, 0, 6, 51);     // unknown opcode
      9:  return enc_i(6'h08, 0, 6, 7);      // ADDI r6 = 7
      10: return enc_i(6'h05, 6, 0, 2);      // BNE taken -> 13
      11: return enc_i(6'h08, 0, 6, 99);     // skipped
      12: return enc_i(6'h2B, 0, 6, 51);     // skipped
      13: return enc_i(6'h2B, 0, 6, 50);     // SW r6 -> 50
      14: return enc_i(6'h2B, 0, 2, 52);     // SW r2 -> 52
      15: return enc_i(6'h08, 0, 0, 9);      // ADDI r0 = 9 (ignored)
      16: return enc_i(6'h2B, 0, 0, 53);     // SW r0 -> 53
      17: return enc_i(6'h05, 1, 0, -1);     // BNE loop to itself
      40: return 32'h1234_5678;
      default: return 32'h0;
    endcase
  endfunction

  function automatic int exp_pc(int k);
    if (k < 10) return k + 1;
    if (k < 14) return k + 3;
    return 17;
  endfunction

  function automatic int exp_cpi(int pc);
    case (pc)
      3: return 5;   // load
      7: return 3;   // untaken branch
      8: return 2;   // unknown opcode
      default: return 4;
    endcase
  endfunction

  function automatic string req_of(int pc);
    case (pc)
      1, 9, 15: return "R4";
      2, 4:     return "R3";
      3:        return "R5";
      5, 6, 13, 14, 16: return "R6";
      7, 10, 17: return "R7";
      8:        return "R9";
      default:  return "R1";
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic peek_check(string req, int addr, logic [31:0] exp);
    peek_addr = AW'(addr);
    #1;
    check(req, peek_data, exp);
  endtask

  int  ev_pc  [20];
  int  ev_cyc [20];
  int  ev_n = 0;
  logic prev_f;

  initial begin
    rst_n = 1'b0; ld_we = 1'b0; ld_addr = '0; ld_data = '0; peek_addr = '0;
    for (int a = 0; a < (1 << AW); a++) begin
      @(negedge clk);
      ld_we = 1'b1; ld_addr = AW'(a); ld_data = program_word(a);
    end
    @(negedge clk);
    ld_we = 1'b0;
    // R11: reset state
    check("R11", pc_o, 32'h0);
    check("R11", {31'h0, fetch_o}, 32'h1);
    rst_n = 1'b1;
    prev_f = 1'b1;
    for (int cyc = 0; cyc < 150; cyc++) begin
      @(negedge clk);
      if (fetch_o && !prev_f && ev_n < 20) begin
        ev_pc[ev_n] = int'(pc_o);
        ev_cyc[ev_n] = cyc;
        ev_n++;
      end
      prev_f = fetch_o;
    end
    check("R1", 32'(ev_n >= 17), 32'h1);
    for (int k = 0; k < 17; k++)
      if (k < ev_n) check(k == 10 ? "R7" : "R1", 32'(ev_pc[k]), 32'(exp_pc(k)));
    for (int k = 0; k < 16; k++)
      if (k + 1 < ev_n)
        check(req_of(exp_pc(k)), 32'(ev_cyc[k+1] - ev_cyc[k]), 32'(exp_cpi(exp_pc(k))));
    peek_check("R5", 48, 32'h1234_567A);   // R5 and R3: load then add
    peek_check("R3", 49, 32'h2);
    peek_check("R7", 50, 32'h7);            // only reached via taken branch
    peek_check("R7", 51, 32'h0);            // skipped store
    peek_check("R4", 52, 32'hFFFF_FFFD);    // sign-extended immediate
    peek_check("R8", 53, 32'h0);            // register 0 stays zero
    peek_check("R9", 40, 32'h1234_5678);    // nothing else disturbed
    peek_check("R10", 10, program_word(10));
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule